// File: doc/BRIEF.md
# Oversampling Serial Receiver With Error Flags

This block recovers asynchronous serial characters from a single line using an enable pulse that arrives an oversampling factor of times per bit. It waits for a falling edge on an idle-high line, confirms the start bit half a bit later, then samples every data bit, the optional parity bit and the stop bit one full bit period apart. The recovered character lands in a one-entry holding buffer together with three error flags: frame error, overrun and parity error.

Character length, parity mode and an address-filtering mode are selected by static configuration inputs. In the address-filtering mode, characters whose most significant data bit is 0 are thrown away without touching the buffer or any flag. This lets a node on a shared line ignore data that is meant for other nodes. Software-side logic reads a character by pulsing a pop strobe. Dropping the enable empties the buffer and stops reception.

Top module: `ovs_serial_rx`

## Requirements
- R1: After reset, `rx_full`, `rx_data`, `rx_bit9` and all three error flags are 0.
- R2: Data bits arrive least significant first. `cfg_size` codes 0, 1, 2, 3 and 4 select 5, 6, 7, 8 and 9 data bits; codes 5 to 7 behave as 8. `rx_data` holds data bits 0 to 7, with bits above the character length reading 0. `rx_bit9` holds data bit 8 in 9-bit mode and is 0 otherwise.
- R3: `cfg_parity` 2'b10 selects even parity, where the parity bit equals the XOR of the data bits. 2'b11 selects odd parity, where it is the inverse of that XOR. 2'b00 and 2'b01 mean that no parity bit is sent. `err_parity` is 1 only when parity is enabled and the received parity bit differs from the expected value.
- R4: `err_frame` is 1 when the stop bit of the buffered character was sampled as 0. A line that stays low after such a stop bit does not start a new character until it has been seen high.
- R5: Only one stop bit is checked. A start bit that follows immediately after one stop bit is received as the next character.
- R6: The start bit is checked again OSR/2 ticks after the falling edge. A low pulse that has ended by then is ignored and nothing is received.
- R7: `rx_full` is 1 while the buffer holds an unread character. A one-cycle `rd_pop` empties the buffer and clears the three error flags in the next cycle.
- R8: If a start bit is confirmed while the buffer is still full, `err_overrun` is set on the buffered character. The buffered character is kept, and the new character is discarded when it completes, unless a pop has emptied the buffer by then.
- R9: When `cfg_mpcm` is 1, a character whose most significant data bit is 0 is discarded, leaving `rx_full` and all flags unchanged. A character whose most significant data bit is 1 is received normally; in 9-bit mode this bit is `rx_bit9`.
- R10: While `rx_en` is 0, the buffer is empty, all error flags read 0 and no character is received.
- R11: Bit timing advances only on cycles where `os_tick` is 1, so characters are received correctly at any tick rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable; 0 empties the buffer |
| os_tick | input | 1 | Oversampling enable, OSR pulses per bit |
| rxd_in | input | 1 | Serial line, idle high |
| cfg_size | input | 3 | Character length code |
| cfg_parity | input | 2 | Parity mode |
| cfg_mpcm | input | 1 | Address-filtering mode |
| rd_pop | input | 1 | Read strobe that empties the buffer |
| rx_data | output | 8 | Low eight data bits of the buffered character |
| rx_bit9 | output | 1 | Ninth data bit in 9-bit mode |
| rx_full | output | 1 | Receive-complete: the buffer holds a character |
| err_frame | output | 1 | Stop bit of the buffered character was 0 |
| err_overrun | output | 1 | A start was confirmed while the buffer was full |
| err_parity | output | 1 | Parity mismatch on the buffered character |

## Verification
The bench builds the receiver with OSR = 8 and mostly drives `os_tick` on every clock, so a bit lasts eight cycles. This makes frames short enough to send every character value at 5, 6 and 7 data bits across all four parity codes, plus spread samples at 8 and 9 bits. A second phase slows the tick to one pulse in three clocks. Separate scenarios cover a short start glitch, a back-to-back frame with a pop in flight, overrun, address filtering at 8 and 9 bits, and disabling with a flagged character held.

// File: rtl/ovs_rx_pkg.sv
package ovs_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [8:0] data;
        logic       frame_err;
        logic       par_err;
    } rx_char_t;

    // character length from the size code; unused codes fall back to 8
    function automatic logic [3:0] data_len(input logic [2:0] code);
        case (code)
            3'd0:    return 4'd5;
            3'd1:    return 4'd6;
            3'd2:    return 4'd7;
            3'd4:    return 4'd9;
            default: return 4'd8;
        endcase
    endfunction

    // expected parity bit; unreceived bits are zero so a full xor works
    function automatic logic par_expect(input logic [8:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

    // most significant received bit of a right-aligned character
    function automatic logic top_bit(input logic [8:0] d, input logic [3:0] len);
        return |(d & (9'd1 << (len - 4'd1)));
    endfunction

endpackage

// File: rtl/rx_in_sync.sv
module rx_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rx_bit_engine.sv
module rx_bit_engine
    import ovs_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       tick,
    input  logic       rxd,
    input  logic [2:0] size_code,
    input  logic [1:0] par_mode,
    output logic       start_ok,
    output logic       done,
    output rx_char_t   char_out
);
    localparam int CW = (OSR > 2) ? $clog2(OSR) : 1;
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);
    localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);

    rx_state_e     st;
    logic [CW-1:0] cnt;
    logic [3:0]    idx;
    logic [8:0]    sr;
    logic          line_hi;
    logic          pe;
    logic [3:0]    len;
    logic          at_last;

    assign len     = data_len(size_code);
    assign at_last = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            idx      <= '0;
            sr       <= '0;
            line_hi  <= 1'b0;
            pe       <= 1'b0;
            start_ok <= 1'b0;
            done     <= 1'b0;
            char_out <= '0;
        end else begin
            start_ok <= 1'b0;
            done     <= 1'b0;
            if (tick) begin
                case (st)
                    ST_IDLE: begin
                        line_hi <= rxd;
                        if (line_hi && !rxd) begin
                            st  <= ST_START;
                            cnt <= '0;
                        end
                    end
                    ST_START: begin
                        if (cnt == MID) begin
                            cnt <= '0;
                            if (!rxd) begin
                                st       <= ST_DATA;
                                idx      <= '0;
                                sr       <= '0;
                                pe       <= 1'b0;
                                start_ok <= 1'b1;
                            end else begin
                                st      <= ST_IDLE;
                                line_hi <= 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (at_last) begin
                            cnt <= '0;
                            sr  <= {rxd, sr[8:1]};
                            idx <= idx + 4'd1;
                            if (idx == len - 4'd1)
                                st <= par_mode[1] ? ST_PAR : ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (at_last) begin
                            cnt <= '0;
                            pe  <= rxd ^ par_expect(sr, par_mode[0]);
                            st  <= ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (at_last) begin
                            cnt                <= '0;
                            done               <= 1'b1;
                            char_out.data      <= sr >> (4'd9 - len);
                            char_out.frame_err <= !rxd;
                            char_out.par_err   <= pe;
                            line_hi            <= rxd;
                            st                 <= ST_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    // R11: a completed character only ever follows a tick
    assert_done_on_tick_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(tick));

    // R6: a start is only accepted while the line is still low
    assert_start_still_low_R6: assert property (@(posedge clk) disable iff (rst)
        start_ok |-> $past(!rxd));

    // R10: switching off returns the engine to idle with no output
    assert_idle_when_off_R10: assert property (@(posedge clk) disable iff (rst)
        !en |=> (st == ST_IDLE && !done && !start_ok));
endmodule

// File: rtl/rx_hold_buf.sv
module rx_hold_buf
    import ovs_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       pop,
    input  logic       start_ok,
    input  logic       done,
    input  rx_char_t   char_in,
    input  logic       mpcm,
    input  logic [2:0] size_code,
    output logic       full,
    output rx_char_t   hold,
    output logic       ovr
);
    logic keep;
    logic store;

    assign keep  = !mpcm || top_bit(char_in.data, data_len(size_code));
    assign store = done && keep && (!full || pop);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            full <= 1'b0;
            hold <= '0;
            ovr  <= 1'b0;
        end else begin
            if (store) begin
                hold <= char_in;
                full <= 1'b1;
                ovr  <= 1'b0;
            end else if (pop) begin
                hold <= '0;
                full <= 1'b0;
                ovr  <= 1'b0;
            end
            if (start_ok && full && !pop)
                ovr <= 1'b1;
        end
    end

    // R7: a pop with nothing arriving leaves the buffer empty
    assert_pop_empties_R7: assert property (@(posedge clk) disable iff (rst)
        (pop && full && !done) |=> !full);

    // R8: a confirmed start against a full buffer raises overrun
    assert_overrun_set_R8: assert property (@(posedge clk) disable iff (rst)
        (en && start_ok && full && !pop) |=> ovr);

    // R9: filtered characters never fill an empty buffer
    assert_mp_drop_R9: assert property (@(posedge clk) disable iff (rst)
        (en && done && mpcm && !top_bit(char_in.data, data_len(size_code)) && !full) |=> !full);

    // R10: disabling empties the buffer
    assert_off_empties_R10: assert property (@(posedge clk) disable iff (rst)
        !en |=> !full);

    // R10: no flag is visible without a character
    assert_flags_need_char_R10: assert property (@(posedge clk) disable iff (rst)
        !full |-> !(ovr || hold.frame_err || hold.par_err));
endmodule

// File: rtl/ovs_serial_rx.sv
module ovs_serial_rx
    import ovs_rx_pkg::*;
#(
    parameter int OSR       = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_en,
    input  logic       os_tick,
    input  logic       rxd_in,
    input  logic [2:0] cfg_size,
    input  logic [1:0] cfg_parity,
    input  logic       cfg_mpcm,
    input  logic       rd_pop,
    output logic [7:0] rx_data,
    output logic       rx_bit9,
    output logic       rx_full,
    output logic       err_frame,
    output logic       err_overrun,
    output logic       err_parity
);
    logic     rxd_s;
    logic     start_ok;
    logic     done;
    rx_char_t fresh;
    rx_char_t held;

    rx_in_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (rxd_in),
        .q   (rxd_s)
    );

    rx_bit_engine #(.OSR(OSR)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .en        (rx_en),
        .tick      (os_tick),
        .rxd       (rxd_s),
        .size_code (cfg_size),
        .par_mode  (cfg_parity),
        .start_ok  (start_ok),
        .done      (done),
        .char_out  (fresh)
    );

    rx_hold_buf u_buf (
        .clk       (clk),
        .rst       (rst),
        .en        (rx_en),
        .pop       (rd_pop),
        .start_ok  (start_ok),
        .done      (done),
        .char_in   (fresh),
        .mpcm      (cfg_mpcm),
        .size_code (cfg_size),
        .full      (rx_full),
        .hold      (held),
        .ovr       (err_overrun)
    );

    assign rx_data    = held.data[7:0];
    assign rx_bit9    = held.data[8];
    assign err_frame  = held.frame_err;
    assign err_parity = held.par_err;

    // R1: the cycle after reset shows an empty buffer
    assert_reset_empty_R1: assert property (@(posedge clk)
        $past(rst) |-> (!rx_full && !err_frame && !err_overrun && !err_parity));
endmodule

// File: tb/test_ovs_serial_rx.sv
`timescale 1ns/1ps
module test_ovs_serial_rx;
    localparam int OSR = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_en = 1'b0;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic [2:0] cfg_size = 3'd3;
    logic [1:0] cfg_parity = 2'b00;
    logic       cfg_mpcm = 1'b0;
    logic       rd_pop = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9, rx_full, err_frame, err_overrun, err_parity;

    int total = 0;
    int bad = 0;
    int tick_div = 1;
    int tcnt = 0;
    bit finished = 0;

    ovs_serial_rx #(.OSR(OSR)) i_ovs_serial_rx (
        .clk(clk), .rst(rst), .rx_en(rx_en), .os_tick(os_tick), .rxd_in(rxd),
        .cfg_size(cfg_size), .cfg_parity(cfg_parity), .cfg_mpcm(cfg_mpcm),
        .rd_pop(rd_pop), .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_full(rx_full),
        .err_frame(err_frame), .err_overrun(err_overrun), .err_parity(err_parity)
    );

    always #4 clk = ~clk;

    always @(negedge clk) begin
        if (tcnt + 1 >= tick_div) begin
            tcnt    <= 0;
            os_tick <= 1'b1;
        end else begin
            tcnt    <= tcnt + 1;
            os_tick <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        int c = 0;
        while (c < n) begin
            @(posedge clk);
            if (os_tick) c++;
        end
        @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        rxd = b;
        wait_ticks(OSR);
    endtask

    task automatic idle(input int n);
        rxd = 1'b1;
        wait_ticks(n);
    endtask

    function automatic int len_of(input logic [2:0] code);
        return (code <= 3'd2) ? 5 + int'(code) : (code == 3'd4 ? 9 : 8);
    endfunction

    function automatic logic [8:0] mask_of(input logic [8:0] v, input int nb);
        logic [8:0] m = '0;
        for (int i = 0; i < nb; i++) m[i] = v[i];
        return m;
    endfunction

    function automatic logic par_of(input logic [8:0] v, input int nb, input logic odd);
        logic p = odd;
        for (int i = 0; i < nb; i++) p ^= v[i];
        return p;
    endfunction

    task automatic send_frame(input logic [8:0] v, input logic stopv, input logic flip);
        int nb = len_of(cfg_size);
        send_bit(1'b0);
        for (int i = 0; i < nb; i++) send_bit(v[i]);
        if (cfg_parity[1]) send_bit(par_of(v, nb, cfg_parity[0]) ^ flip);
        send_bit(stopv);
        rxd = 1'b1;
    endtask

    // packs {bit9, data, fe, ovr, pe}
    task automatic expect_char(input string tag, input logic [8:0] v,
                               input logic fe, input logic ovr, input logic pe);
        logic [8:0] m = mask_of(v, len_of(cfg_size));
        logic [11:0] exp = {m, fe, ovr, pe};
        logic [11:0] act = {rx_bit9, rx_data, err_frame, err_overrun, err_parity};
        check(rx_full == 1'b1, "R7", "rx_full after frame", int'(rx_full), 1);
        check(act == exp, tag, "{bit9,data,fe,ovr,pe}", int'(act), int'(exp));
    endtask

    task automatic pop_check(input string tag);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        check({rx_full, err_frame, err_overrun, err_parity} == 4'b0, tag,
              "full/flags after pop", int'({rx_full, err_frame, err_overrun, err_parity}), 0);
    endtask

    task automatic expect_empty(input string tag, input string what);
        check({rx_full, err_frame, err_overrun, err_parity} == 4'b0, tag, what,
              int'({rx_full, err_frame, err_overrun, err_parity}), 0);
    endtask

    initial begin
        logic [8:0] capA;
        repeat (3) @(negedge clk);
        rx_en = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check({rx_full, rx_bit9, rx_data, err_frame, err_overrun, err_parity} == '0,
              "R1", "outputs after reset",
              int'({rx_full, rx_bit9, rx_data, err_frame, err_overrun, err_parity}), 0);
        idle(4);

        // R2 / R3 sweep over sizes, values and parity codes
        for (int sc = 0; sc < 5; sc++) begin
            int nb;
            int cnt;
            cfg_size = 3'(sc);
            nb  = len_of(cfg_size);
            cnt = (nb <= 7) ? (1 << nb) : 48;
            for (int k = 0; k < cnt; k++) begin
                logic [8:0] v;
                logic flip;
                v = (nb <= 7) ? 9'(k) : 9'((k * 37 + 5) & ((1 << nb) - 1));
                cfg_parity = 2'(k % 4);
                flip = (k % 3 == 0);
                send_frame(v, 1'b1, flip);
                idle(2);
                expect_char(cfg_parity[1] ? "R3" : "R2", v, 1'b0, 1'b0,
                            cfg_parity[1] & flip);
                pop_check("R7");
            end
        end
        cfg_parity = 2'b00;

        // R2 unused size code behaves as 8 bits
        cfg_size = 3'd6;
        send_frame(9'h1C3, 1'b1, 1'b0);
        idle(2);
        expect_char("R2", 9'h0C3, 1'b0, 1'b0, 1'b0);
        pop_check("R7");

        // R4 frame error with a long low stop bit, every size
        for (int sc = 0; sc < 5; sc++) begin
            cfg_size = 3'(sc);
            send_frame(9'h155, 1'b0, 1'b0);
            idle(2);
            expect_char("R4", 9'h155, 1'b1, 1'b0, 1'b0);
            idle(3 * OSR);
            check(err_overrun == 1'b0, "R4", "no false start after low stop", int'(err_overrun), 0);
            pop_check("R4");
        end

        // R6 glitch rejection
        cfg_size = 3'd3;
        rxd = 1'b0;
        wait_ticks(2);
        idle(3 * OSR);
        expect_empty("R6", "after short low pulse");
        send_frame(9'h05A, 1'b1, 1'b0);
        idle(2);
        expect_char("R6", 9'h05A, 1'b0, 1'b0, 1'b0);
        pop_check("R6");

        // R5 back-to-back frames with one stop bit
        fork
            begin
                send_frame(9'h0A7, 1'b1, 1'b0);
                send_frame(9'h03C, 1'b1, 1'b0);
                idle(2);
            end
            begin
                while (!rx_full) @(negedge clk);
                capA = {rx_bit9, rx_data};
                rd_pop = 1'b1;
                @(negedge clk);
                rd_pop = 1'b0;
            end
        join
        check(capA == 9'h0A7, "R5", "first of back-to-back", int'(capA), 'hA7);
        expect_char("R5", 9'h03C, 1'b0, 1'b0, 1'b0);
        pop_check("R5");

        // R8 overrun keeps old char and discards the new one
        send_frame(9'h011, 1'b1, 1'b0);
        idle(2);
        send_frame(9'h0EE, 1'b1, 1'b0);
        idle(2);
        expect_char("R8", 9'h011, 1'b0, 1'b1, 1'b0);
        pop_check("R8");
        idle(OSR);
        expect_empty("R8", "second char discarded");

        // R9 address filtering, 8-bit then 9-bit
        cfg_mpcm = 1'b1;
        send_frame(9'h012, 1'b0, 1'b0);
        idle(2 * OSR);
        expect_empty("R9", "data char dropped, no flags");
        send_frame(9'h092, 1'b1, 1'b0);
        idle(2);
        expect_char("R9", 9'h092, 1'b0, 1'b0, 1'b0);
        pop_check("R9");
        cfg_size = 3'd4;
        send_frame(9'h0AB, 1'b1, 1'b0);
        idle(2);
        expect_empty("R9", "9-bit data char dropped");
        send_frame(9'h1AB, 1'b1, 1'b0);
        idle(2);
        expect_char("R9", 9'h1AB, 1'b0, 1'b0, 1'b0);
        pop_check("R9");
        cfg_mpcm = 1'b0;

        // R10 disable flushes a flagged char and blocks reception
        cfg_size = 3'd3;
        cfg_parity = 2'b10;
        send_frame(9'h0F0, 1'b0, 1'b1);
        idle(2);
        expect_char("R10", 9'h0F0, 1'b1, 1'b0, 1'b1);
        rx_en = 1'b0;
        @(negedge clk);
        expect_empty("R10", "after disable");
        send_frame(9'h033, 1'b1, 1'b0);
        idle(2);
        expect_empty("R10", "frame while disabled");
        rx_en = 1'b1;
        idle(2);
        expect_empty("R10", "after re-enable");

        // R11 slower tick rate
        tick_div = 3;
        idle(2);
        cfg_parity = 2'b11;
        send_frame(9'h0A5, 1'b1, 1'b0);
        idle(2);
        expect_char("R11", 9'h0A5, 1'b0, 1'b0, 1'b0);
        pop_check("R11");
        cfg_size = 3'd4;
        send_frame(9'h14C, 1'b1, 1'b1);
        idle(2);
        expect_char("R11", 9'h14C, 1'b0, 1'b0, 1'b1);
        pop_check("R11");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(190000 * 8);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule